// File: doc/BRIEF.md
# Per-Processor Interrupt Claim Slice

This block is the processor-facing half of a multi-core interrupt controller. It sees 256 level-sensitive interrupt IDs: IDs 0 to 31 come from sources private to its own core, and IDs 32 to 255 arrive already routed from the shared side of the controller. For each ID it keeps an enable flag and a claimed ("in service") flag. It always has the lowest-numbered ID ready that is asserted, enabled and not claimed.

Software runs the slice through a small register port with separate read and write channels. Enabling and disabling are done one ID at a time by writing the ID number to a set register or a clear register. Software takes an interrupt by reading the claim register, which marks the returned ID as in service. It ends servicing by writing the ID to the done register. Another register lets software send an inter-processor interrupt: the slice emits an ID and a target-core mask for one cycle. A global gate bit decides whether the slice raises the core's interrupt request line.

Top module: `pcc_slice`

## Requirements
- R1: After reset all enable and claimed flags are clear and the gate bit is 0. `cpu_irq` and `ipi_valid` are low, a claim read returns the idle value 0xFFFFFFFF, and bit 31 of the peek register is 0.
- R2: A write to the enable-set register (offset 0x0A0) with an ID in data bits [7:0] enables that ID and no other.
- R3: A write to the enable-clear register (offset 0x0A4) with an ID in data bits [7:0] disables that ID and no other.
- R4: A read of the claim register (offset 0x06C) returns, zero-extended, the lowest-numbered ID that is asserted, enabled and unclaimed. When there is no such ID it returns 0xFFFFFFFF.
- R5: An ID returned by a claim read is marked claimed at that clock edge and is not returned again until a write of its number to the done register (offset 0x0B4). After that write, if its line is still high, it is eligible again.
- R6: A read of the peek register (offset 0x068) returns bit 31 = 1 when an eligible ID exists, with that lowest ID in bits [7:0] (0xFF when none). The read has no side effect.
- R7: `cpu_irq` is high exactly when bit 0 of the gate register (offset 0x000, readable back) is 1 and at least one eligible ID exists.
- R8: A write to the signal register (offset 0x060) drives `ipi_valid` high for the following cycle only. It presents data bits [3:0] on `ipi_id` and data bits [15:8] on `ipi_mask`.
- R9: A claim read and a done write may fall in the same cycle, and both take effect.
- R10: `priv_lines[i]` is ID i. `shared_lines[j]` is ID 32+j.
- R11: For the ID-carrying writes only data bits [7:0] count. Higher data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a claim read has its side effect at the clock edge |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from current state while rd_en is high, else 0 |
| priv_lines | input | 32 | Level inputs for private IDs 0 to 31 |
| shared_lines | input | 224 | Level inputs for routed IDs 32 to 255 |
| ipi_valid | output | 1 | One-cycle inter-processor interrupt request |
| ipi_id | output | 4 | ID carried by the request |
| ipi_mask | output | 8 | Target core mask |
| cpu_irq | output | 1 | Interrupt request to this core |

## Verification
The claim read and the done write use separate channels, so software can take one ID in the same edge where it finishes another. The bench drives both strobes in one cycle. It checks that the claim returns the value computed before the edge, that the finished ID can become eligible again, and that the newly claimed ID is hidden. It also repeats the case where the finished and the claimed IDs race against lower-numbered lines. Random traffic mixes enable writes, line changes, claims and done writes against a bench model.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    localparam int NUM_IDS    = 256;
    localparam int NUM_PRIV   = 32;
    localparam int ID_W       = $clog2(NUM_IDS);
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int MASK_W     = 8;
    localparam int IPI_ID_W   = 4;

    localparam logic [ADDR_W-1:0] OFF_GATE  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_SIG   = 12'h060;
    localparam logic [ADDR_W-1:0] OFF_PEEK  = 12'h068;
    localparam logic [ADDR_W-1:0] OFF_CLAIM = 12'h06C;
    localparam logic [ADDR_W-1:0] OFF_SETEN = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFF_CLREN = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFF_DONE  = 12'h0B4;

    localparam logic [DATA_W-1:0] IDLE_WORD = '1;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_GATE,
        WOP_SIG,
        WOP_SETEN,
        WOP_CLREN,
        WOP_DONE
    } wr_op_e;

    typedef struct packed {
        logic [MASK_W-1:0]   mask;
        logic [IPI_ID_W-1:0] id;
    } ipi_t;

    function automatic wr_op_e decode_wr(input logic en, input logic [ADDR_W-1:0] a);
        wr_op_e op;
        op = WOP_NONE;
        if (en) begin
            case (a)
                OFF_GATE:  op = WOP_GATE;
                OFF_SIG:   op = WOP_SIG;
                OFF_SETEN: op = WOP_SETEN;
                OFF_CLREN: op = WOP_CLREN;
                OFF_DONE:  op = WOP_DONE;
                default:   op = WOP_NONE;
            endcase
        end
        return op;
    endfunction
endpackage

// File: rtl/pcc_flag_bank.sv
module pcc_flag_bank #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_v,
    input  logic [IW-1:0] set_id,
    input  logic          clr_v,
    input  logic [IW-1:0] clr_id,
    output logic [N-1:0]  flags
);
    // Set wins when both name the same ID.
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags[g] <= 1'b0;
            else if (set_v && set_id == IW'(g))
                flags[g] <= 1'b1;
            else if (clr_v && clr_id == IW'(g))
                flags[g] <= 1'b0;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set_v |=> flags[$past(set_id)]); // R2
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr_v && !(set_v && set_id == clr_id)) |=> !flags[$past(clr_id)]); // R3
endmodule

// File: rtl/pcc_lowest.sv
module pcc_lowest #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] id
);
    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                id    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pcc_slice.sv
module pcc_slice
    import pcc_pkg::*;
#(
    parameter int N_IDS  = NUM_IDS,
    parameter int N_PRIV = NUM_PRIV,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    parameter int MW     = MASK_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic                   rd_en,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    input  logic [N_PRIV-1:0]      priv_lines,
    input  logic [N_IDS-N_PRIV-1:0] shared_lines,
    output logic                   ipi_valid,
    output logic [IPI_ID_W-1:0]    ipi_id,
    output logic [MW-1:0]          ipi_mask,
    output logic                   cpu_irq
);
    localparam int IW = $clog2(N_IDS);

    logic [N_IDS-1:0] lines, en_flags, act_flags, cand;
    logic             gate_q;
    logic             pick_v;
    logic [IW-1:0]    pick_id;
    logic [IW-1:0]    wid;
    logic             claim_v;
    wr_op_e           wop;
    ipi_t             ipi_q;

    assign lines = {shared_lines, priv_lines};
    assign wop   = decode_wr(wr_en, wr_addr);
    assign wid   = wr_data[IW-1:0];

    pcc_flag_bank #(.N(N_IDS), .IW(IW)) u_enable (
        .clk(clk), .rst(rst),
        .set_v(wop == WOP_SETEN), .set_id(wid),
        .clr_v(wop == WOP_CLREN), .clr_id(wid),
        .flags(en_flags)
    );

    assign cand = lines & en_flags & ~act_flags;

    pcc_lowest #(.N(N_IDS), .IW(IW)) u_pick (
        .vec(cand), .found(pick_v), .id(pick_id)
    );

    assign claim_v = rd_en && (rd_addr == OFF_CLAIM) && pick_v;

    pcc_flag_bank #(.N(N_IDS), .IW(IW)) u_active (
        .clk(clk), .rst(rst),
        .set_v(claim_v), .set_id(pick_id),
        .clr_v(wop == WOP_DONE), .clr_id(wid),
        .flags(act_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q    <= 1'b0;
            ipi_valid <= 1'b0;
            ipi_q     <= '0;
        end else begin
            ipi_valid <= (wop == WOP_SIG);
            if (wop == WOP_GATE)
                gate_q <= wr_data[0];
            if (wop == WOP_SIG) begin
                ipi_q.id   <= wr_data[IPI_ID_W-1:0];
                ipi_q.mask <= wr_data[8 +: MW];
            end
        end
    end

    assign ipi_id   = ipi_q.id;
    assign ipi_mask = ipi_q.mask;
    assign cpu_irq  = gate_q && pick_v;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                OFF_GATE:  rd_data[0] = gate_q;
                OFF_PEEK: begin
                    rd_data[DW-1]   = pick_v;
                    rd_data[IW-1:0] = pick_v ? pick_id : '1;
                end
                OFF_CLAIM: rd_data = pick_v ? DW'(pick_id) : IDLE_WORD;
                default:   rd_data = '0;
            endcase
        end
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        pick_v |-> (cand[pick_id] && ((cand & ((N_IDS'(1) << pick_id) - N_IDS'(1))) == '0))); // R4
    AST_CLAIM_HIDES: assert property (@(posedge clk) disable iff (rst)
        claim_v |=> act_flags[$past(pick_id)]); // R5
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (|(lines & en_flags))); // R7
    AST_IPI_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        ipi_valid |-> $past(wr_en && wr_addr == OFF_SIG)); // R8
endmodule

// File: tb/pcc_slice_test.sv
module pcc_slice_test;
    localparam int PERIOD = 10;
    localparam logic [11:0] A_GATE = 12'h000, A_SIG = 12'h060, A_PEEK = 12'h068,
                            A_CLAIM = 12'h06C, A_SETEN = 12'h0A0, A_CLREN = 12'h0A4,
                            A_DONE = 12'h0B4;

    logic clk = 0, rst = 1;
    logic wr_en = 0, rd_en = 0;
    logic [11:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [255:0] lines_m = '0;
    logic ipi_valid, cpu_irq;
    logic [3:0] ipi_id;
    logic [7:0] ipi_mask;

    logic [255:0] en_m = '0, act_m = '0;
    logic gate_m = 0;
    int checks = 0, errors = 0;

    always #(PERIOD/2) clk = ~clk;

    pcc_slice uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .priv_lines(lines_m[31:0]), .shared_lines(lines_m[255:32]),
        .ipi_valid(ipi_valid), .ipi_id(ipi_id), .ipi_mask(ipi_mask),
        .cpu_irq(cpu_irq)
    );

    function automatic int lowest(input logic [255:0] v);
        for (int i = 0; i < 256; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_claim();
        int e = lowest(lines_m & en_m & ~act_m);
        return (e < 0) ? 32'hFFFF_FFFF : 32'(e);
    endfunction

    function automatic logic [31:0] exp_peek();
        int e = lowest(lines_m & en_m & ~act_m);
        return (e < 0) ? 32'h0000_00FF : (32'h8000_0000 | 32'(e));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
        case (a)
            A_SETEN: en_m[d[7:0]] = 1'b1;
            A_CLREN: en_m[d[7:0]] = 1'b0;
            A_DONE:  act_m[d[7:0]] = 1'b0;
            A_GATE:  gate_m = d[0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [11:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        #(PERIOD/4);
        check(req, rd_data, exp);
        @(posedge clk); #1;
        rd_en = 0;
        if (a == A_CLAIM && exp != 32'hFFFF_FFFF) act_m[exp[7:0]] = 1'b1;
    endtask

    task automatic claim(input string req);
        rd(A_CLAIM, req, exp_claim());
    endtask

    // claim read and done write in one cycle
    task automatic claim_and_done(input logic [7:0] did, input string req);
        logic [31:0] e;
        e = exp_claim();
        @(negedge clk);
        rd_en = 1; rd_addr = A_CLAIM;
        wr_en = 1; wr_addr = A_DONE; wr_data = {24'h0, did};
        #(PERIOD/4);
        check(req, rd_data, e);
        @(posedge clk); #1;
        rd_en = 0; wr_en = 0;
        act_m[did] = 1'b0;
        if (e != 32'hFFFF_FFFF) act_m[e[7:0]] = 1'b1;
    endtask

    task automatic check_irq(input string req);
        @(negedge clk);
        check(req, {31'h0, cpu_irq}, {31'h0, gate_m && (lowest(lines_m & en_m & ~act_m) >= 0)});
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        @(negedge clk);
        check("R1 cpu_irq", {31'h0, cpu_irq}, 32'h0);
        check("R1 ipi_valid", {31'h0, ipi_valid}, 32'h0);
        rd(A_CLAIM, "R1 idle claim", 32'hFFFF_FFFF);
        rd(A_PEEK, "R1 peek", 32'h0000_00FF);
        rd(A_GATE, "R1 gate", 32'h0);

        // R2 / R11 enable a single ID, upper data bits ignored
        lines_m[5] = 1; lines_m[6] = 1;
        wr(A_SETEN, 32'hABCD_1205);
        rd(A_PEEK, "R2 R11 only id5 enabled", 32'h8000_0005);
        claim("R4 claim id5");
        rd(A_CLAIM, "R2 id6 not enabled", 32'hFFFF_FFFF);
        wr(A_DONE, 32'h0000_0005);
        // R5 line still high -> eligible again
        rd(A_PEEK, "R5 reeligible after done", 32'h8000_0005);

        // R3 disable only one
        wr(A_SETEN, 6);
        wr(A_CLREN, 32'hFF00_0005);
        rd(A_PEEK, "R3 id5 disabled id6 kept", 32'h8000_0006);

        // R7 gate
        check_irq("R7 gate off");
        wr(A_GATE, 1);
        rd(A_GATE, "R7 gate readback", 32'h1);
        check_irq("R7 gate on");
        claim("R5 claim id6");
        check_irq("R7 nothing eligible");
        rd(A_CLAIM, "R5 claimed not returned", 32'hFFFF_FFFF);
        lines_m[6] = 0;
        wr(A_DONE, 6);
        rd(A_CLAIM, "R5 done with line low", 32'hFFFF_FFFF);

        // R10 mapping: shared bit0 = ID 32, priv 31 lower wins
        wr(A_SETEN, 32); wr(A_SETEN, 31);
        lines_m[32] = 1;
        rd(A_PEEK, "R10 shared bit0 is id32", 32'h8000_0020);
        lines_m[31] = 1;
        rd(A_PEEK, "R10 private id31 beats 32", 32'h8000_001F);
        wr(A_SETEN, 255); lines_m[255] = 1;

        // R9 claim and done same cycle
        claim("R4 claim 31");
        claim_and_done(8'd31, "R9 claim 32 while finishing 31");
        rd(A_PEEK, "R9 31 back, 32 hidden", 32'h8000_001F);
        claim_and_done(8'd32, "R9 claim 31 while finishing 32");
        claim("R9 32 eligible again");
        claim("R4 highest id 255");
        rd(A_CLAIM, "R4 all claimed", 32'hFFFF_FFFF);
        wr(A_DONE, 31); wr(A_DONE, 32); wr(A_DONE, 255);

        // R8 IPI
        @(negedge clk);
        wr_en = 1; wr_addr = A_SIG; wr_data = 32'hFFFF_A50F;
        @(posedge clk); #1;
        wr_en = 0;
        check("R8 ipi_valid", {31'h0, ipi_valid}, 32'h1);
        check("R8 ipi_id", {28'h0, ipi_id}, 32'hF);
        check("R8 ipi_mask", {24'h0, ipi_mask}, 32'hA5);
        @(posedge clk); #1;
        check("R8 one cycle", {31'h0, ipi_valid}, 32'h0);

        // random mix
        for (int it = 0; it < 3000; it++) begin
            int op = $urandom % 10;
            logic [7:0] id = 8'($urandom % 48);
            if ($urandom % 4 == 0) id = 8'($urandom);
            case (op)
                0, 1: lines_m[id] = ~lines_m[id];
                2:    wr(A_SETEN, {8'($urandom), 16'h0, id});
                3:    wr(A_CLREN, {24'h0, id});
                4, 5: claim("R4 random claim");
                6:    wr(A_DONE, {24'h0, id});
                7:    rd(A_PEEK, "R6 random peek", exp_peek());
                8:    claim_and_done(id, "R9 random claim+done");
                default: check_irq("R7 random irq");
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule